// File: doc/BRIEF.md
# Single-Port Synchronous Memory with Selectable Write Mode

This block is a clocked single-port storage array with one address bus, used for both reads and writes. A port enable controls whether anything happens on a given edge. A write enable selects a write instead of a read. On a read edge, the word at the addressed location is captured into an output holding register.

On a write edge, the value the holding register takes is set by the parameter `WR_MODE`. The three choices are:
- Transparent: the incoming word.
- Read-before-write: the word that was stored at the address before the write.
- Hold: the register is left untouched.

An optional second output register, selected by `OUT_PIPE`, adds one more edge of latency. It only advances on edges where the port enable is high.

Reset clears the output registers only. The array contents are not reset and are undefined at power-up. Data width and address width are parameters, with defaults of 16 bits and 1024 words.

Top module: `sp_mem_wmode`

## Requirements
- R1: A read edge (en=1, we=0) makes `rdata` equal to the word stored at `addr`, visible after that edge when `OUT_PIPE`=0.
- R2: With `WR_MODE`=0 (transparent), a write edge stores `wdata` at `addr` and makes `rdata` equal to that same `wdata` after the edge.
- R3: With `WR_MODE`=1 (read-before-write), a write edge makes `rdata` equal to the word held at `addr` before the write, while `wdata` is stored.
- R4: With `WR_MODE`=2 (hold), a write edge stores `wdata` and leaves `rdata` unchanged.
- R5: When `WR_MODE` is not overridden, the block behaves as transparent (`WR_MODE`=0).
- R6: On an edge with en=0, no location is written (even when we=1) and `rdata` keeps its value.
- R7: With `OUT_PIPE`=1, `rdata` shows the holding-register value one enabled edge later. The extra register advances only on edges with en=1.
- R8: Synchronous active-high `rst` sets `rdata` to zero and leaves the array contents intact.
- R9: Two consecutive write edges to the same address behave per mode. In read-before-write mode, the second write returns the first write's data. A read right after either write returns the last written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the output registers, active high |
| en | input | 1 | Port enable |
| we | input | 1 | Write enable, qualified by `en` |
| addr | input | AW | Word address |
| wdata | input | DW | Word to store |
| rdata | output | DW | Output word |

## Verification
Suppose the holding register were loaded with the wrong source on a write edge: new data where old data belongs, or an update where it should hold. The bad value shows on `rdata` on the very next edge without the pipeline register, or one enabled edge later with it. Back-to-back writes to one address are compared against an independent reference array for all three modes at once.

A corrupted array entry or a write leaking through a disabled edge stays hidden until that address is read. For that reason, every test step rereads the locations it touched. A pipeline register that advanced while disabled shows up as an `rdata` change during a stall.

// File: rtl/sp_mem_wmode.sv
module sp_mem_wmode #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int WR_MODE = 0,
  parameter bit OUT_PIPE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur, hold_q, hold_d;

  assign cur = mem[addr];

  always_ff @(posedge clk)
    if (en && we) mem[addr] <= wdata;

  generate
    if (WR_MODE == 0) begin : g_transparent
      assign hold_d = we ? wdata : cur;
    end else if (WR_MODE == 1) begin : g_read_first
      assign hold_d = cur;
    end else begin : g_hold
      assign hold_d = we ? hold_q : cur;
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst) hold_q <= '0;
    else if (en) hold_q <= hold_d;

  generate
    if (OUT_PIPE) begin : g_pipe
      logic [DW-1:0] pipe_q;
      always_ff @(posedge clk)
        if (rst) pipe_q <= '0;
        else if (en) pipe_q <= hold_q;
      assign rdata = pipe_q;
    end else begin : g_direct
      assign rdata = hold_q;
    end
  endgenerate
endmodule

// File: rtl/sp_mem_wmode_chk.sv
module sp_mem_wmode_chk #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int WR_MODE = 0,
  parameter bit OUT_PIPE = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rdata));

  // R8
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> rdata == '0);

  generate
    if (!OUT_PIPE) begin : g_direct
      // R9
      wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (en && we) ##1 (en && !we && addr == $past(addr)) |=> rdata == $past(wdata, 2));

      if (WR_MODE == 0) begin : g_wf
        // R2
        transparent_chk: assert property (@(posedge clk) disable iff (rst)
          (en && we) |=> rdata == $past(wdata));
      end else if (WR_MODE == 1) begin : g_rf
        // R3
        old_data_chk: assert property (@(posedge clk) disable iff (rst)
          (en && we) ##1 (en && we && addr == $past(addr)) |=> rdata == $past(wdata, 2));
      end else begin : g_nc
        // R4
        hold_on_write_chk: assert property (@(posedge clk) disable iff (rst)
          (en && we) |=> $stable(rdata));
      end
    end else begin : g_pipe
      // R7
      pipe_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && we) ##1 en |=> (WR_MODE != 0) || rdata == $past(wdata, 2));
    end
  endgenerate
endmodule

bind sp_mem_wmode sp_mem_wmode_chk #(
  .DW(DW), .AW(AW), .WR_MODE(WR_MODE), .OUT_PIPE(OUT_PIPE)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
);

// File: tb/sp_mem_wmode_tb_top.sv
module sp_mem_wmode_tb_top;
  localparam int DW = 16;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_wf, rd_rf, rd_nc, rd_pp;

  always #10 clk = ~clk;

  // R5: default parameters, transparent mode
  sp_mem_wmode dut_i (.clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rd_wf));
  sp_mem_wmode #(.WR_MODE(1)) dut_rf (.clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rd_rf));
  sp_mem_wmode #(.WR_MODE(2)) dut_nc (.clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rd_nc));
  sp_mem_wmode #(.OUT_PIPE(1'b1)) dut_pp (.clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rd_pp));

  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] e_wf, e_rf, e_nc, e_pp;
  int n_cmp = 0, n_bad = 0;
  bit chk_on = 1'b0;

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(bit r, bit e, bit w, int a, logic [DW-1:0] d, string tag);
    logic [DW-1:0] old;
    rst = r; en = e; we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      e_wf = '0; e_rf = '0; e_nc = '0; e_pp = '0;
    end else if (e) begin
      old = ref_mem[a];
      e_pp = e_wf;
      if (w) begin
        ref_mem[a] = d;
        e_wf = d; e_rf = old;
      end else begin
        e_wf = old; e_rf = old; e_nc = old;
      end
    end
    if (chk_on) begin
      check({tag, " transparent"}, rd_wf, e_wf);
      check({tag, " read-first"}, rd_rf, e_rf);
      check({tag, " hold"}, rd_nc, e_nc);
      check({tag, " piped"}, rd_pp, e_pp);
    end
    rst = 1'b0; en = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset;
    chk_on = 1'b1;
    step(1, 0, 0, 0, '0, "R8 reset");
    step(1, 0, 0, 0, '0, "R8 reset");
  endtask

  task automatic t_preload;
    chk_on = 1'b0;
    for (int a = 0; a < 8; a++) step(0, 1, 1, a, DW'(16'h1000 + a), "preload");
    step(0, 1, 1, 1023, 16'hBEEF, "preload");
    chk_on = 1'b1;
  endtask

  task automatic t_reads;
    for (int a = 7; a >= 0; a--) step(0, 1, 0, a, '0, "R1 read");
    step(0, 1, 0, 1023, '0, "R1 read top");
  endtask

  task automatic t_writes;
    step(0, 1, 0, 2, '0, "R1 read");
    step(0, 1, 1, 3, 16'hA5A5, "R2 R3 R4 R5 write");
    step(0, 1, 1, 4, 16'h5A5A, "R2 R3 R4 R5 write");
    step(0, 1, 0, 3, '0, "R1 read back");
    step(0, 1, 0, 4, '0, "R1 read back");
  endtask

  task automatic t_same_addr;
    step(0, 1, 1, 5, 16'h1111, "R9 first write");
    step(0, 1, 1, 5, 16'h2222, "R9 second write");
    step(0, 1, 1, 5, 16'h3333, "R9 third write");
    step(0, 1, 0, 5, '0, "R9 read after");
  endtask

  task automatic t_disabled;
    step(0, 1, 0, 6, '0, "R6 read");
    step(0, 0, 1, 6, 16'hDEAD, "R6 disabled write");
    step(0, 0, 0, 7, '0, "R6 disabled read");
    step(0, 1, 0, 6, '0, "R6 location intact");
    step(0, 1, 0, 6, '0, "R6 location intact");
  endtask

  task automatic t_pipe;
    step(0, 1, 1, 0, 16'h7E7E, "R7 write");
    step(0, 0, 0, 1, '0, "R7 stall");
    step(0, 0, 0, 2, '0, "R7 stall");
    step(0, 1, 0, 1, '0, "R7 advance");
    step(0, 1, 0, 2, '0, "R7 advance");
    step(0, 1, 0, 0, '0, "R7 advance");
  endtask

  task automatic t_reset_keeps;
    step(1, 0, 0, 0, '0, "R8 mid reset");
    step(0, 1, 0, 5, '0, "R8 contents kept");
    step(0, 1, 0, 1023, '0, "R8 contents kept");
    step(0, 1, 0, 1023, '0, "R8 contents kept");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_preload();
    t_reads();
    t_writes();
    t_same_addr();
    t_disabled();
    t_pipe();
    t_reset_keeps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule